// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block gathers a large set of level-sensitive interrupt sources and folds them into groups of eight. Each group drives one line to a parent interrupt controller, and the line is high while any source in the group is both pending and enabled. Software controls the enables through a small register bus. It turns sources on with a write-one-to-set register and off with a write-one-to-clear register. It reads the raw pending levels through a status register.

Four consecutive groups share one bank of 32-bit registers, and each group owns one byte lane of every register in its bank. Banks repeat every 0x10 bytes. Inside a bank the word offsets are 0x0 for enable-set, 0x4 for enable-clear and 0xC for status; offset 0x8 is unmapped. The group count is a parameter and is rounded up to whole banks. Sources of a padding group are tied low.

Top module: `irq_group_combiner`

## Requirements
- R1: After a synchronous reset every enable bit is 0, every group output is 0 and the read data is 0.
- R2: A write to bank offset 0x0 sets each enable bit whose data bit is 1. Enable bits whose data bit is 0 keep their value.
- R3: A write to bank offset 0x4 clears each enable bit whose data bit is 1. Enable bits whose data bit is 0 keep their value.
- R4: Group output n is high exactly when some source of group n was high and enabled at the previous clock edge. The output has one register stage, and a disabled pending source never raises it.
- R5: Group n sits in the bank at byte offset (n/4)*0x10. It uses bits [8*(n%4)+7 : 8*(n%4)] of that bank's registers, and source k of the group is input bit 8*n+k.
- R6: A read of bank offset 0xC returns the raw source levels of the bank's four groups, registered once and not masked by enable.
- R7: Writes to offset 0x8 of any bank, and writes to any bank index past the last bank, change no enable. Reads from those addresses return 0.
- R8: Read data appears on the cycle after the read strobe and holds until the next read. A read of offset 0x0 or 0x4 returns the bank's enable vector.
- R9: Writing 0xFF into one group's lane of enable-clear disables all eight sources of that group and leaves every other group's enables unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_GROUPS*8 | Level interrupt sources; bit 8*n+k is source k of group n |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte address; bits [3:2] select the register, upper bits select the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| grp_irq | output | NUM_GROUPS | One level output per group to the parent controller |

## Verification
The assertions assume that the bus never raises a read and a write in the same cycle. They also assume that reset is held for at least two edges, so the delayed source and enable values they compare against are defined. The stimulus drives every input half a cycle away from the sampling edge. It issues each bus access as a single-cycle strobe, keeps reads and writes in separate cycles, and holds reset for four cycles at the start.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int LANE_W  = 8;
  localparam int GRP_PER_BANK = 4;
  localparam int REG_W   = LANE_W * GRP_PER_BANK;

  typedef enum logic [1:0] {
    REG_SET  = 2'd0,
    REG_CLR  = 2'd1,
    REG_RSVD = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  function automatic int banks_for(input int groups);
    return (groups + GRP_PER_BANK - 1) / GRP_PER_BANK;
  endfunction
endpackage

// File: rtl/irqc_bank.sv
module irqc_bank
  import irqc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    set_we,
  input  logic                    clr_we,
  input  logic [REG_W-1:0]        wdata,
  input  logic [REG_W-1:0]        src,
  output logic [REG_W-1:0]        en_q,
  output logic [REG_W-1:0]        stat_q,
  output logic [GRP_PER_BANK-1:0] irq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      stat_q <= '0;
    end else begin
      if (set_we)      en_q <= en_q | wdata;
      else if (clr_we) en_q <= en_q & ~wdata;
      stat_q <= src;
    end
  end

  for (genvar l = 0; l < GRP_PER_BANK; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) irq_q[l] <= 1'b0;
      else     irq_q[l] <= |(src[l*LANE_W +: LANE_W] & en_q[l*LANE_W +: LANE_W]);
    end
  end
endmodule

// File: rtl/irqc_rdmux.sv
module irqc_rdmux
  import irqc_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd,
  input  logic [BANK_W-1:0]          bank_idx,
  input  reg_sel_e                   sel,
  input  logic [NUM_BANKS*REG_W-1:0] en_all,
  input  logic [NUM_BANKS*REG_W-1:0] stat_all,
  output logic [REG_W-1:0]           rdata
);
  logic [REG_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_idx == BANK_W'(b)) begin
        case (sel)
          REG_SET, REG_CLR: rd_next = en_all[b*REG_W +: REG_W];
          REG_STAT:         rd_next = stat_all[b*REG_W +: REG_W];
          default:          rd_next = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_next;
  end
endmodule

// File: rtl/irq_group_combiner.sv
module irq_group_combiner
  import irqc_pkg::*;
#(
  parameter int NUM_GROUPS = 16,
  parameter int ADDR_W     = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_GROUPS*LANE_W-1:0] src_i,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [REG_W-1:0]             bus_wdata,
  output logic [REG_W-1:0]             bus_rdata,
  output logic [NUM_GROUPS-1:0]        grp_irq
);
  localparam int NUM_BANKS = banks_for(NUM_GROUPS);
  localparam int NG_R      = NUM_BANKS * GRP_PER_BANK;
  localparam int BANK_W    = ADDR_W - 4;

  logic [BANK_W-1:0]            bank_idx;
  reg_sel_e                     sel;
  logic [NG_R*LANE_W-1:0]       src_pad;
  logic [NUM_BANKS*REG_W-1:0]   en_all;
  logic [NUM_BANKS*REG_W-1:0]   stat_all;
  logic [NG_R-1:0]              irq_all;

  assign bank_idx = bus_addr[ADDR_W-1:4];
  assign sel      = reg_sel_e'(bus_addr[3:2]);

  always_comb begin
    src_pad = '0;
    src_pad[NUM_GROUPS*LANE_W-1:0] = src_i;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = bus_wr && (bank_idx == BANK_W'(b));

    irqc_bank u_bank (
      .clk    (clk),
      .rst    (rst),
      .set_we (hit && (sel == REG_SET)),
      .clr_we (hit && (sel == REG_CLR)),
      .wdata  (bus_wdata),
      .src    (src_pad[b*REG_W +: REG_W]),
      .en_q   (en_all[b*REG_W +: REG_W]),
      .stat_q (stat_all[b*REG_W +: REG_W]),
      .irq_q  (irq_all[b*GRP_PER_BANK +: GRP_PER_BANK])
    );
  end

  irqc_rdmux #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W)
  ) u_rdmux (
    .clk      (clk),
    .rst      (rst),
    .rd       (bus_rd),
    .bank_idx (bank_idx),
    .sel      (sel),
    .en_all   (en_all),
    .stat_all (stat_all),
    .rdata    (bus_rdata)
  );

  assign grp_irq = irq_all[NUM_GROUPS-1:0];
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
#(
  parameter int NUM_GROUPS = 16,
  parameter int ADDR_W     = 8
) (
  input logic                                        clk,
  input logic                                        rst,
  input logic [NUM_GROUPS*LANE_W-1:0]                src_i,
  input logic                                        bus_wr,
  input logic                                        bus_rd,
  input logic [ADDR_W-1:0]                           bus_addr,
  input logic [REG_W-1:0]                            bus_wdata,
  input logic [REG_W-1:0]                            bus_rdata,
  input logic [NUM_GROUPS-1:0]                       grp_irq,
  input logic [banks_for(NUM_GROUPS)*REG_W-1:0]      en_all
);
  localparam int NB = banks_for(NUM_GROUPS);
  localparam int BW = ADDR_W - 4;

  logic [BW-1:0] bidx;
  logic [1:0]    rsel;
  logic          unmapped;
  assign bidx     = bus_addr[ADDR_W-1:4];
  assign rsel     = bus_addr[3:2];
  assign unmapped = (int'(bidx) >= NB) || (rsel == 2'd2);

  for (genvar b = 0; b < NB; b++) begin : g_b
    p_set_r2: assert property (@(posedge clk) disable iff (rst)
      bus_wr && bidx == BW'(b) && rsel == 2'd0 |=>
        ((en_all[b*REG_W +: REG_W] & $past(bus_wdata)) == $past(bus_wdata)) &&
        ((en_all[b*REG_W +: REG_W] & ~$past(bus_wdata)) ==
         ($past(en_all[b*REG_W +: REG_W]) & ~$past(bus_wdata))));

    p_clr_r3: assert property (@(posedge clk) disable iff (rst)
      bus_wr && bidx == BW'(b) && rsel == 2'd1 |=>
        ((en_all[b*REG_W +: REG_W] & $past(bus_wdata)) == '0));
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_g
    p_out_r4: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> grp_irq[g] ==
        (|($past(src_i[g*LANE_W +: LANE_W]) & $past(en_all[g*LANE_W +: LANE_W]))));
  end

  p_unmapped_wr_r7: assert property (@(posedge clk) disable iff (rst)
    bus_wr && unmapped |=> $stable(en_all));

  p_unmapped_rd_r7: assert property (@(posedge clk) disable iff (rst)
    bus_rd && unmapped |=> bus_rdata == '0);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !bus_rd && !$past(rst) |=> $stable(bus_rdata));
endmodule

bind irq_group_combiner irqc_chk #(
  .NUM_GROUPS (NUM_GROUPS),
  .ADDR_W     (ADDR_W)
) u_chk (.*);

// File: tb/sim_irq_group_combiner.sv
`timescale 1ns/1ps
module sim_irq_group_combiner;
  localparam int NG = 16;
  localparam int AW = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NG*8-1:0] src_i = '0;
  logic           bus_wr = 1'b0;
  logic           bus_rd = 1'b0;
  logic [AW-1:0]  bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [NG-1:0]  grp_irq;

  irq_group_combiner #(.NUM_GROUPS(NG), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .src_i(src_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .grp_irq(grp_irq)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] en_m [4];
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic [31:0] last_rd;
  logic        rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor: pops one expected item per completed read
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s rdata actual %h expected %h", t, bus_rdata, e);
      end
    end
  end

  function automatic logic [NG-1:0] exp_irq(input logic [NG*8-1:0] s);
    logic [NG-1:0] r;
    for (int g = 0; g < NG; g++)
      r[g] = |(s[g*8 +: 8] & en_m[g/4][(g%4)*8 +: 8]);
    return r;
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    int b;
    int s;
    b = int'(a) >> 4;
    s = (int'(a) >> 2) & 3;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (b < 4 && s == 0) en_m[b] = en_m[b] | d;
    if (b < 4 && s == 1) en_m[b] = en_m[b] & ~d;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    last_rd = e;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input string t);
    @(negedge clk);
    checks++;
    if (grp_irq !== exp_irq(src_i)) begin
      errors++;
      $display("FAIL %s grp_irq actual %h expected %h", t, grp_irq, exp_irq(src_i));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) en_m[i] = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    checks++;
    if (grp_irq !== '0 || bus_rdata !== '0) begin
      errors++;
      $display("FAIL R1 reset actual %h/%h expected 0/0", grp_irq, bus_rdata);
    end
    rst = 1'b0;
    rd(8'h00, 32'h0, "R1 set readback");
    rd(8'h34, 32'h0, "R1 clr readback");

    // R4/R6: all pending but nothing enabled; status raw
    src_i = '1;
    chk_irq("R4 disabled pending");
    rd(8'h0C, 32'hFFFF_FFFF, "R6 status bank0");
    rd(8'h2C, 32'hFFFF_FFFF, "R6 status bank2");
    src_i = '0;

    // R2: set and readback
    wr(8'h00, 32'h0000_0001);
    rd(8'h00, 32'h0000_0001, "R2 set bit");
    rd(8'h04, 32'h0000_0001, "R8 clr offset returns enables");
    src_i[0] = 1'b1;
    chk_irq("R4 enabled source");
    src_i = '0; src_i[1] = 1'b1;
    chk_irq("R4 other source disabled");
    src_i = '0;

    // R2 zeros keep; R5 mapping
    wr(8'h00, 32'h0000_0100);
    rd(8'h00, 32'h0000_0101, "R2 zero bits unchanged");
    wr(8'h10, 32'h8000_0000);
    wr(8'h30, 32'hFF00_0000);
    src_i[63] = 1'b1; src_i[8] = 1'b1; src_i[127] = 1'b1;
    chk_irq("R5 group lanes");
    checks++;
    if (grp_irq !== 16'h8082) begin
      errors++;
      $display("FAIL R5 literal actual %h expected %h", grp_irq, 16'h8082);
    end
    rd(8'h10, 32'h8000_0000, "R5 bank1 enable");
    rd(8'h1C, 32'h8000_0000, "R6 status bank1");

    // R7: unmapped writes and reads
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'hF4, 32'hFFFF_FFFF);
    rd(8'h00, 32'h0000_0101, "R7 enables after unmapped writes");
    rd(8'h08, 32'h0, "R7 read offset 8");
    rd(8'h40, 32'h0, "R7 read past last bank");
    chk_irq("R7 outputs unchanged");

    // R8: read data holds
    repeat (3) @(negedge clk);
    checks++;
    if (bus_rdata !== 32'h0) begin
      errors++;
      $display("FAIL R8 hold actual %h expected %h", bus_rdata, 32'h0);
    end

    // R3: clear
    wr(8'h04, 32'h0000_0001);
    rd(8'h00, 32'h0000_0100, "R3 clear one bit");

    // R9: clear whole lane of group 1 only
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h04, 32'h0000_FF00);
    rd(8'h00, 32'hFFFF_00FF, "R9 lane cleared");
    src_i = '1;
    chk_irq("R9 outputs");
    checks++;
    if (grp_irq !== 16'h808D) begin
      errors++;
      $display("FAIL R9 literal actual %h expected %h", grp_irq, 16'h808D);
    end
    src_i = '0;
    chk_irq("R4 deassert");

    // R6: partial pattern in bank 3
    src_i[127:96] = 32'hA5C3_0F81;
    chk_irq("R4 bank3 pattern");
    rd(8'h3C, 32'hA5C3_0F81, "R6 status pattern");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule